// File: doc/BRIEF.md
# Privilege and Alignment Check Unit

This block sits next to the execute stage of a protected-mode processor model and decides, for each access the stage presents, whether it may proceed or must trap. It compares the current privilege level against a stored two-bit I/O privilege field. It enforces the counter-read gates set by two control bits. It raises a page fault on writes to read-only pages when write protection is on. It also traps misaligned data accesses, but only when the alignment flag, the alignment-mask control bit and user privilege (level 3) all hold together.

The I/O privilege field lives inside the block. A flags-write request updates it, and the update is honoured only at privilege level 0. Every request yields exactly one registered result one clock later: either a grant pulse or a fault pulse carrying a fault code. When several rules fail at once, one fixed priority chooses the code.

Top module: `priv_align_check`

## Requirements
- R1: An I/O request (kind code 0) is granted when the current privilege level is numerically less than or equal to the stored I/O privilege field; otherwise it faults with code 1 (protection).
- R2: A flags-write request (kind code 1) loads `req_new_iopl` into the stored field only at privilege level 0. At any other level the field keeps its old value. A flags write is always granted and never faults.
- R3: An alignment fault (code 3) is raised for a memory read (kind 4) or memory write (kind 5) only when it is misaligned, the alignment flag is 1, the alignment-mask bit is 1 and the privilege level is 3. If any one of these conditions is missing, the access gets no alignment fault.
- R4: Size code 0 (1 byte) is never misaligned. Size code 1 (2 bytes) is misaligned when address bit 0 is set. Size code 2 (4 bytes) is misaligned when address bits 1:0 are nonzero. Size code 3 (8 bytes) is misaligned when address bits 2:0 are nonzero.
- R5: A time-stamp read (kind 2) faults with code 1 when time-stamp disable is 1 and the privilege level is nonzero. Otherwise it is granted.
- R6: A performance-counter read (kind 3) faults with code 1 when counter enable is 0 and the privilege level is nonzero. Otherwise it is granted.
- R7: A memory write to a read-only page faults with code 2 (page) when write protect is 1. With write protect 0, or on a writable page, or for a read, no page fault is raised.
- R8: When more than one fault applies, the code reported is protection (1) first, then page (2), then alignment (3). A misaligned user-level write to a protected read-only page therefore reports code 2.
- R9: The result appears in the cycle after the request strobe. Exactly one of `grant` and `fault_vld` pulses for one cycle, and neither pulses without a request. Kind codes 6 and 7 fault with code 1.
- R10: Reset clears `grant`, `fault_vld` and `fault_code` to 0 and returns the stored I/O privilege field to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pl | input | 2 | Current privilege level |
| flag_ac | input | 1 | Alignment-check flag |
| ctl_am | input | 1 | Alignment-mask control bit |
| ctl_tsd | input | 1 | Time-stamp disable control bit |
| ctl_pce | input | 1 | Performance-counter enable control bit |
| ctl_wp | input | 1 | Write-protect control bit |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_kind | input | 3 | Request kind code |
| req_size | input | 2 | Memory access size code |
| req_addr | input | ADDR_W | Memory access address |
| req_page_ro | input | 1 | Target page is read-only |
| req_new_iopl | input | 2 | New I/O privilege value for a flags write |
| iopl_q | output | 2 | Stored I/O privilege field |
| grant | output | 1 | Registered permit pulse |
| fault_vld | output | 1 | Registered fault pulse |
| fault_code | output | 2 | Registered fault code (0 none, 1 protection, 2 page, 3 alignment) |

## Verification
The hardest case to reach is a single access that breaks two rules at once, because only a memory write can carry both a page fault and an alignment fault. The stimulus builds that case directly: a 4-byte write to an odd address on a read-only page, at level 3, with the alignment flag, the mask bit and write protection all set, so the priority order is actually tested. The I/O privilege field can only be seen through `iopl_q` and later I/O results. The stimulus first loads the field at level 0, then tries rejected writes at levels 1 and 3, and finally reads the field back through the port and through I/O grants.

// File: rtl/pac_pkg.sv
// Package: shared encodings for the privilege and alignment check unit.
// Assumes: request kinds 6 and 7 are reserved and treated as illegal.
package pac_pkg;

    localparam int SIZE_W = 2;
    localparam int SIZE_CODES = 1 << SIZE_W;
    localparam int PL_W = 2;

    typedef enum logic [2:0] {
        K_IO       = 3'd0,
        K_FLAGS_WR = 3'd1,
        K_TSC_RD   = 3'd2,
        K_PMC_RD   = 3'd3,
        K_MEM_RD   = 3'd4,
        K_MEM_WR   = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_GP   = 2'd1,
        FC_PF   = 2'd2,
        FC_AC   = 2'd3
    } fault_code_e;

endpackage

// File: rtl/pac_iopl_reg.sv
// Module: pac_iopl_reg
// Holds the I/O privilege field. A flags write loads a new value only
// when issued at privilege level 0; otherwise the old value is kept.
// Assumes: one request per strobe cycle; synchronous active-low reset.
module pac_iopl_reg
    import pac_pkg::*;
#(
    parameter logic [PL_W-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_kind,
    input  logic [PL_W-1:0] cur_pl,
    input  logic [PL_W-1:0] new_val,
    output logic [PL_W-1:0] iopl_q
);

    logic load_en;

    // Purpose: accept the write only from the most privileged level.
    always_comb begin
        load_en = req_valid && (req_kind == K_FLAGS_WR) && (cur_pl == '0);
    end

    // Purpose: field storage with reset to the configured value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iopl_q <= RST_VAL;
        end else if (load_en) begin
            iopl_q <= new_val;
        end
    end

endmodule

// File: rtl/pac_priv_rules.sv
// Module: pac_priv_rules
// Evaluates the privilege-level rules that produce a protection fault:
// I/O level compare, time-stamp and counter read gates, reserved kinds.
// Assumes: purely combinational; inputs are stable for the request cycle.
module pac_priv_rules
    import pac_pkg::*;
(
    input  logic [2:0]      req_kind,
    input  logic [PL_W-1:0] cur_pl,
    input  logic [PL_W-1:0] iopl,
    input  logic            ctl_tsd,
    input  logic            ctl_pce,
    output logic            gp_fail
);

    logic pl_is_zero;

    // Purpose: decode the kind and apply the matching privilege rule.
    always_comb begin
        pl_is_zero = (cur_pl == '0);
        unique case (req_kind)
            K_IO:       gp_fail = (cur_pl > iopl);
            K_FLAGS_WR: gp_fail = 1'b0;
            K_TSC_RD:   gp_fail = ctl_tsd && !pl_is_zero;
            K_PMC_RD:   gp_fail = !ctl_pce && !pl_is_zero;
            K_MEM_RD,
            K_MEM_WR:   gp_fail = 1'b0;
            default:    gp_fail = 1'b1;
        endcase
    end

endmodule

// File: rtl/pac_misalign.sv
// Module: pac_misalign
// Flags an access whose address is not a multiple of its size. One low
// bit mask per size code is generated; size code n covers 2**n bytes.
// Assumes: ADDR_W is at least SIZE_CODES-1 bits wide.
module pac_misalign
    import pac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [SIZE_W-1:0] req_size,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              misaligned
);

    logic [SIZE_CODES-1:0] mis_vec;

    genvar g;
    generate
        for (g = 0; g < SIZE_CODES; g++) begin : g_size
            localparam logic [ADDR_W-1:0] LOW_MASK =
                ADDR_W'((64'd1 << g) - 64'd1);
            // Purpose: any set low address bit breaks alignment for this size.
            always_comb begin
                mis_vec[g] = |(req_addr & LOW_MASK);
            end
        end
    endgenerate

    // Purpose: select the result for the requested size.
    always_comb begin
        misaligned = mis_vec[req_size];
    end

endmodule

// File: rtl/pac_fault_prio.sv
// Module: pac_fault_prio
// Fixed-priority encoder: protection, then page, then alignment.
// Assumes: purely combinational; all-clear input yields FC_NONE.
module pac_fault_prio
    import pac_pkg::*;
(
    input  logic        gp_fail,
    input  logic        pf_fail,
    input  logic        ac_fail,
    output logic        any_fail,
    output logic [1:0]  code
);

    // Purpose: pick the highest-priority failing rule.
    always_comb begin
        any_fail = gp_fail || pf_fail || ac_fail;
        if (gp_fail) begin
            code = FC_GP;
        end else if (pf_fail) begin
            code = FC_PF;
        end else if (ac_fail) begin
            code = FC_AC;
        end else begin
            code = FC_NONE;
        end
    end

endmodule

// File: rtl/priv_align_check.sv
// Module: priv_align_check (top)
// Judges each request against the privilege, write-protect and
// alignment rules and registers one grant or one coded fault pulse.
// Assumes: req_valid is a one-cycle strobe per request; control and
// flag inputs are valid in the strobe cycle; synchronous active-low reset.
module priv_align_check
    import pac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_pl,
    input  logic              flag_ac,
    input  logic              ctl_am,
    input  logic              ctl_tsd,
    input  logic              ctl_pce,
    input  logic              ctl_wp,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_page_ro,
    input  logic [1:0]        req_new_iopl,
    output logic [1:0]        iopl_q,
    output logic              grant,
    output logic              fault_vld,
    output logic [1:0]        fault_code
);

    localparam logic [PL_W-1:0] USER_PL = '1;

    logic       gp_fail;
    logic       pf_fail;
    logic       ac_fail;
    logic       misaligned;
    logic       is_mem;
    logic       any_fail;
    logic [1:0] code_d;

    pac_iopl_reg #(
        .RST_VAL ('0)
    ) u_iopl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .cur_pl    (cur_pl),
        .new_val   (req_new_iopl),
        .iopl_q    (iopl_q)
    );

    pac_priv_rules u_rules (
        .req_kind (req_kind),
        .cur_pl   (cur_pl),
        .iopl     (iopl_q),
        .ctl_tsd  (ctl_tsd),
        .ctl_pce  (ctl_pce),
        .gp_fail  (gp_fail)
    );

    pac_misalign #(
        .ADDR_W (ADDR_W)
    ) u_misalign (
        .req_size   (req_size),
        .req_addr   (req_addr),
        .misaligned (misaligned)
    );

    // Purpose: page fault and three-condition alignment trap for memory kinds.
    always_comb begin
        is_mem  = (req_kind == K_MEM_RD) || (req_kind == K_MEM_WR);
        pf_fail = (req_kind == K_MEM_WR) && ctl_wp && req_page_ro;
        ac_fail = is_mem && misaligned && flag_ac && ctl_am &&
                  (cur_pl == USER_PL);
    end

    pac_fault_prio u_prio (
        .gp_fail  (gp_fail),
        .pf_fail  (pf_fail),
        .ac_fail  (ac_fail),
        .any_fail (any_fail),
        .code     (code_d)
    );

    // Purpose: register the decision one cycle after the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant      <= 1'b0;
            fault_vld  <= 1'b0;
            fault_code <= FC_NONE;
        end else begin
            grant      <= req_valid && !any_fail;
            fault_vld  <= req_valid && any_fail;
            fault_code <= req_valid ? code_d : FC_NONE;
        end
    end

endmodule

// File: rtl/pac_checker.sv
// Module: pac_checker
// Property checks on the port behaviour of priv_align_check, bound below.
// Assumes: same parameters as the top; observes only, drives nothing.
module pac_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cur_pl,
    input logic              flag_ac,
    input logic              ctl_am,
    input logic              ctl_tsd,
    input logic              ctl_pce,
    input logic              ctl_wp,
    input logic              req_valid,
    input logic [2:0]        req_kind,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_page_ro,
    input logic [1:0]        req_new_iopl,
    input logic [1:0]        iopl_q,
    input logic              grant,
    input logic              fault_vld,
    input logic [1:0]        fault_code
);

    AST_IO_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd0 && cur_pl > iopl_q)
        |=> (fault_vld && fault_code == 2'd1)); // R1

    AST_IOPL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd1 && cur_pl != 2'd0)
        |=> ($stable(iopl_q) && grant)); // R2

    AST_AC_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && fault_code == 2'd3)
        |-> ($past(cur_pl) == 2'd3 && $past(flag_ac) && $past(ctl_am))); // R3

    AST_BYTE_NO_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0)
        |=> !(fault_vld && fault_code == 2'd3)); // R4

    AST_TSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd2 && ctl_tsd && cur_pl != 2'd0)
        |=> (fault_vld && fault_code == 2'd1)); // R5

    AST_PMC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd3 && !ctl_pce && cur_pl != 2'd0)
        |=> (fault_vld && fault_code == 2'd1)); // R6

    AST_WP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd5 && ctl_wp && req_page_ro)
        |=> (fault_vld && fault_code == 2'd2)); // R7 R8

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, fault_vld})); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !fault_vld)); // R9

    AST_RESULT_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || fault_vld)); // R9

    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_vld |-> (fault_code == 2'd0)); // R10

endmodule

bind priv_align_check pac_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_pl       (cur_pl),
    .flag_ac      (flag_ac),
    .ctl_am       (ctl_am),
    .ctl_tsd      (ctl_tsd),
    .ctl_pce      (ctl_pce),
    .ctl_wp       (ctl_wp),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_size     (req_size),
    .req_addr     (req_addr),
    .req_page_ro  (req_page_ro),
    .req_new_iopl (req_new_iopl),
    .iopl_q       (iopl_q),
    .grant        (grant),
    .fault_vld    (fault_vld),
    .fault_code   (fault_code)
);

// File: tb/priv_align_check_test.sv
// Bench for priv_align_check: a vector table walked by one loop, then
// directed checks for reset, idle cycles and pulse width.
module priv_align_check_test;

    localparam int ADDR_W = 32;
    localparam int NVEC = 29;

    // Vector layout (24 bits):
    // [23:21] kind, [20:19] pl, [18] ac, [17] am, [16] tsd, [15] pce,
    // [14] wp, [13] ro, [12:11] size, [10:7] addr low, [6:5] new iopl,
    // [4] expected grant, [3:2] expected code, [1:0] expected iopl after.
    localparam logic [23:0] VEC [NVEC] = '{
        {3'd1, 2'd0, 6'b000000, 2'd0, 4'd0, 2'd2, 1'b1, 2'd0, 2'd2}, // 0  R2 load
        {3'd0, 2'd2, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 1  R1 equal
        {3'd0, 2'd3, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b0, 2'd1, 2'd2}, // 2  R1 above
        {3'd1, 2'd1, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 3  R2 ignored
        {3'd1, 2'd3, 6'b000000, 2'd0, 4'd0, 2'd3, 1'b1, 2'd0, 2'd2}, // 4  R2 ignored
        {3'd2, 2'd1, 6'b001000, 2'd0, 4'd0, 2'd0, 1'b0, 2'd1, 2'd2}, // 5  R5 deny
        {3'd2, 2'd0, 6'b001000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 6  R5 level 0
        {3'd2, 2'd3, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 7  R5 open
        {3'd3, 2'd3, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b0, 2'd1, 2'd2}, // 8  R6 deny
        {3'd3, 2'd0, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 9  R6 level 0
        {3'd3, 2'd3, 6'b000100, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 10 R6 open
        {3'd5, 2'd0, 6'b000011, 2'd2, 4'd0, 2'd0, 1'b0, 2'd2, 2'd2}, // 11 R7 fault
        {3'd5, 2'd0, 6'b000001, 2'd2, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 12 R7 wp off
        {3'd4, 2'd0, 6'b000011, 2'd2, 4'd0, 2'd0, 1'b1, 2'd0, 2'd2}, // 13 R7 read
        {3'd4, 2'd3, 6'b110000, 2'd2, 4'd2, 2'd0, 1'b0, 2'd3, 2'd2}, // 14 R3 R4 4B
        {3'd4, 2'd3, 6'b110000, 2'd1, 4'd1, 2'd0, 1'b0, 2'd3, 2'd2}, // 15 R4 2B odd
        {3'd4, 2'd3, 6'b110000, 2'd1, 4'd2, 2'd0, 1'b1, 2'd0, 2'd2}, // 16 R4 2B even
        {3'd4, 2'd3, 6'b110000, 2'd0, 4'd3, 2'd0, 1'b1, 2'd0, 2'd2}, // 17 R4 byte
        {3'd4, 2'd3, 6'b100000, 2'd2, 4'd2, 2'd0, 1'b1, 2'd0, 2'd2}, // 18 R3 no mask
        {3'd4, 2'd3, 6'b010000, 2'd2, 4'd2, 2'd0, 1'b1, 2'd0, 2'd2}, // 19 R3 no flag
        {3'd4, 2'd2, 6'b110000, 2'd2, 4'd2, 2'd0, 1'b1, 2'd0, 2'd2}, // 20 R3 level 2
        {3'd5, 2'd3, 6'b110011, 2'd2, 4'd1, 2'd0, 1'b0, 2'd2, 2'd2}, // 21 R8 PF over AC
        {3'd5, 2'd3, 6'b110001, 2'd3, 4'd4, 2'd0, 1'b0, 2'd3, 2'd2}, // 22 R4 8B
        {3'd4, 2'd3, 6'b110000, 2'd3, 4'd8, 2'd0, 1'b1, 2'd0, 2'd2}, // 23 R4 8B ok
        {3'd6, 2'd0, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b0, 2'd1, 2'd2}, // 24 R9 reserved
        {3'd1, 2'd0, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd0}, // 25 R2 load 0
        {3'd0, 2'd1, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b0, 2'd1, 2'd0}, // 26 R1 above
        {3'd0, 2'd0, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd0}, // 27 R1 level 0
        {3'd5, 2'd0, 6'b000010, 2'd2, 4'd0, 2'd0, 1'b1, 2'd0, 2'd0}  // 28 R7 writable
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cur_pl = '0;
    logic              flag_ac = 1'b0;
    logic              ctl_am = 1'b0;
    logic              ctl_tsd = 1'b0;
    logic              ctl_pce = 1'b0;
    logic              ctl_wp = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [1:0]        req_size = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_page_ro = 1'b0;
    logic [1:0]        req_new_iopl = '0;
    logic [1:0]        iopl_q;
    logic              grant;
    logic              fault_vld;
    logic [1:0]        fault_code;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    priv_align_check #(.ADDR_W(ADDR_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cur_pl       (cur_pl),
        .flag_ac      (flag_ac),
        .ctl_am       (ctl_am),
        .ctl_tsd      (ctl_tsd),
        .ctl_pce      (ctl_pce),
        .ctl_wp       (ctl_wp),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_size     (req_size),
        .req_addr     (req_addr),
        .req_page_ro  (req_page_ro),
        .req_new_iopl (req_new_iopl),
        .iopl_q       (iopl_q),
        .grant        (grant),
        .fault_vld    (fault_vld),
        .fault_code   (fault_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic eg,
                             input logic [1:0] ec, input logic [1:0] ei);
        check({req, " grant"}, int'(grant), int'(eg));
        check({req, " fault_vld"}, int'(fault_vld), int'(!eg));
        check({req, " code"}, int'(fault_code), int'(ec));
        check({req, " iopl"}, int'(iopl_q), int'(ei));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic apply(input logic [23:0] v);
        req_kind     = v[23:21];
        cur_pl       = v[20:19];
        flag_ac      = v[18];
        ctl_am       = v[17];
        ctl_tsd      = v[16];
        ctl_pce      = v[15];
        ctl_wp       = v[14];
        req_page_ro  = v[13];
        req_size     = v[12:11];
        req_addr     = {28'hABCDE00, v[10:7]};
        req_new_iopl = v[6:5];
        req_valid    = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        // R10: state while reset is held
        repeat (3) @(negedge clk);
        check("R10 grant in reset", int'(grant), 0);
        check("R10 fault_vld in reset", int'(fault_vld), 0);
        check("R10 code in reset", int'(fault_code), 0);
        check("R10 iopl in reset", int'(iopl_q), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: requirement named in each table comment
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check_out($sformatf("vec%0d", i), VEC[i][4], VEC[i][3:2], VEC[i][1:0]);
        end

        // R9: a fault pulse lasts one cycle and idle cycles stay quiet
        apply(VEC[2]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 fault pulse", int'(fault_vld), 1);
        @(negedge clk);
        check("R9 fault drops", int'(fault_vld), 0);
        check("R9 no grant idle", int'(grant), 0);
        check("R9 code idle", int'(fault_code), 0);

        // R2: raise the field, then reset mid-run restores it (R10)
        apply({3'd1, 2'd0, 6'b000000, 2'd0, 4'd0, 2'd3, 1'b1, 2'd0, 2'd3});
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 load 3", int'(iopl_q), 3);
        apply({3'd0, 2'd3, 6'b000000, 2'd0, 4'd0, 2'd0, 1'b1, 2'd0, 2'd3});
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 level 3 at iopl 3", int'(grant), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 iopl after reset", int'(iopl_q), 0);
        check("R10 grant after reset", int'(grant), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: aligned 4-byte user access with all trap conditions set
        apply({3'd5, 2'd3, 6'b110000, 2'd2, 4'd12, 2'd0, 1'b1, 2'd0, 2'd0});
        @(negedge clk);
        req_valid = 1'b0;
        check_out("R4 aligned 4B", 1'b1, 2'd0, 2'd0);

        @(negedge clk);
        finish_run();
    end

endmodule